// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block sequences one conversion of a dual-slope integrating analog-to-digital converter. It drives three registered switch controls for an external integrator: a zero switch that discharges the capacitor, an input switch that feeds the unknown signal, and a reference switch that feeds a fixed reference of the opposite effect. A single counter, clocked by the precision system clock, times every phase.

A conversion starts on a start pulse, or repeats back to back while the continuous flag is high. The integrator is zeroed, then the input is integrated for exactly `INT_LEN` clocks. After one clock with no switch closed, the reference is applied and the same counter measures how long the integrator takes to return to its starting level, as reported by a zero-crossing comparator. That count is the result. The integration window and the de-integration time come from the same clock, so a drift in clock rate scales both phases alike and leaves the result unchanged. If no crossing arrives in time, the block reports overrange with a full-scale code. The comparator input is asynchronous, so it is synchronized, and the synchronizer delay is taken out of the count.

Top module: `dual_slope_seq`

## Requirements
- R1: While and just after reset, every switch output, `done_o`, `ovr_o` and `result_o` are 0.
- R2: A high `start_i` seen in the idle state begins a conversion, whose first phase closes `az_o` for exactly `AZ_LEN` consecutive cycles.
- R3: Each conversion holds `sel_in_o` high for exactly `INT_LEN` consecutive cycles, right after the zeroing phase.
- R4: At most one of `az_o`, `sel_in_o`, `sel_ref_o` is high in any cycle, and at least one cycle with all three low separates the fall of `sel_in_o` from the rise of `sel_ref_o`.
- R5: The result equals the number of cycles `sel_ref_o` was high up to and including the first cycle in which the raw comparator reads low (the `SYNC_STAGES` cycles of synchronizer delay removed); for an integrator driven at a constant rate this is ceil(INT_LEN*Vin/Vref). It is 0 if the comparator already reads low when the reference phase starts.
- R6: If the synchronized comparator is still high in the `2*INT_LEN`-th reference cycle, the reference phase ends after exactly `2*INT_LEN` cycles, `result_o` becomes all ones (2*INT_LEN-1) and `ovr_o` is 1; a result of at most 2*INT_LEN-2 gives `ovr_o` = 0.
- R7: `done_o` is high for exactly one cycle per conversion, in the first cycle in which the new `result_o` and `ovr_o` are visible; they stay unchanged until the next `done_o`.
- R8: `start_i` raised while a conversion is in progress has no effect: no second zeroing phase follows the conversion.
- R9: With `cont_i` high, a new conversion begins on its own: `az_o` rises two cycles after the `done_o` cycle. With `cont_i` and `start_i` low, the block stays idle.
- R10: Scaling the input and the reference rates by the same factor leaves the result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Precision conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin one conversion when idle |
| cont_i | input | 1 | Run conversions back to back |
| cmp_i | input | 1 | Comparator, 1 while the integrator is away from its starting level (asynchronous) |
| az_o | output | 1 | Zero switch for the integrator capacitor |
| sel_in_o | output | 1 | Connect the analog input to the integrator |
| sel_ref_o | output | 1 | Connect the reference to the integrator |
| result_o | output | RES_W | De-integration count, RES_W = clog2(2*INT_LEN) |
| ovr_o | output | 1 | Last result was overrange |
| done_o | output | 1 | One-cycle pulse with each new result |

## Verification
A wrong phase length or a lost transition shows first on the switch pins: the input window, zeroing length or switch gap is off by cycles within the conversion in which it happens, long before the result appears. A wrong count or a wrong synchronizer compensation shows as a result that differs by a constant from ceil(INT_LEN*Vin/Vref) at the very next `done_o`, and the boundary inputs 510/256 and 511/256 pin down where overrange begins. A state machine that leaves idle on a stale start or misses continuous mode shows as an extra or missing zeroing window within two cycles of `done_o`.

// File: rtl/ds_pkg.sv
package ds_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_AZERO = 3'd1,
    ST_INTEG = 3'd2,
    ST_SWAP  = 3'd3,
    ST_DEINT = 3'd4,
    ST_DONE  = 3'd5
  } ds_state_e;

endpackage

// File: rtl/ds_sync.sv
module ds_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/ds_timer.sv
module ds_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_o <= '0;
    else              cnt_o <= cnt_o + 1'b1;
  end

  // R6: a phase never runs the shared counter past its top value
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> cnt_o != '0);

endmodule

// File: rtl/ds_capture.sv
module ds_capture #(
  parameter int RES_W       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             over_i,
  input  logic [RES_W-1:0] cnt_i,
  output logic [RES_W-1:0] result_o,
  output logic             ovr_o
);

  localparam int EXT_W = RES_W + 1;
  localparam logic [EXT_W-1:0] LAT = EXT_W'(SYNC_STAGES);

  logic [EXT_W-1:0] elapsed;
  logic [RES_W-1:0] trimmed;

  always_comb begin
    elapsed = {1'b0, cnt_i} + 1'b1;
    if (elapsed <= LAT) trimmed = '0;
    else                trimmed = RES_W'(elapsed - LAT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      ovr_o    <= 1'b0;
    end else if (load_i) begin
      result_o <= over_i ? '1 : trimmed;
      ovr_o    <= over_i;
    end
  end

  // R6
  ovr_full_scale_chk: assert property (@(posedge clk) disable iff (rst)
    load_i && over_i |=> (result_o == '1) && ovr_o);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(result_o) && $stable(ovr_o));

endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import ds_pkg::*;
#(
  parameter  int INT_LEN     = 256,
  parameter  int AZ_LEN      = 4,
  parameter  int SYNC_STAGES = 2,
  localparam int RES_W       = $clog2(2 * INT_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic             cmp_i,
  output logic             az_o,
  output logic             sel_in_o,
  output logic             sel_ref_o,
  output logic [RES_W-1:0] result_o,
  output logic             ovr_o,
  output logic             done_o
);

  localparam logic [RES_W-1:0] AZ_LAST    = RES_W'(AZ_LEN - 1);
  localparam logic [RES_W-1:0] INT_LAST   = RES_W'(INT_LEN - 1);
  localparam logic [RES_W-1:0] DEINT_LAST = RES_W'(2 * INT_LEN - 1);
  localparam int RUN_W = $clog2(INT_LEN + 1) + 1;

  ds_state_e        state_q, state_n;
  logic [RES_W-1:0] cnt;
  logic             cmp_s;
  logic             cnt_clr;
  logic             cap_load;
  logic             cap_over;

  ds_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (cmp_i),
    .q_o (cmp_s)
  );

  ds_timer #(.CNT_W(RES_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr_i (cnt_clr),
    .cnt_o (cnt)
  );

  always_comb begin
    state_n  = state_q;
    cap_load = 1'b0;
    cap_over = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start_i || cont_i) state_n = ST_AZERO;
      ST_AZERO: if (cnt == AZ_LAST)    state_n = ST_INTEG;
      ST_INTEG: if (cnt == INT_LAST)   state_n = ST_SWAP;
      ST_SWAP:  state_n = ST_DEINT;
      ST_DEINT: begin
        if (!cmp_s) begin
          state_n  = ST_DONE;
          cap_load = 1'b1;
        end else if (cnt == DEINT_LAST) begin
          state_n  = ST_DONE;
          cap_load = 1'b1;
          cap_over = 1'b1;
        end
      end
      ST_DONE:  state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  assign cnt_clr = (state_n != state_q) || (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      az_o      <= 1'b0;
      sel_in_o  <= 1'b0;
      sel_ref_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      state_q   <= state_n;
      az_o      <= (state_n == ST_AZERO);
      sel_in_o  <= (state_n == ST_INTEG);
      sel_ref_o <= (state_n == ST_DEINT);
      done_o    <= (state_n == ST_DONE);
    end
  end

  ds_capture #(.RES_W(RES_W), .SYNC_STAGES(SYNC_STAGES)) u_capture (
    .clk      (clk),
    .rst      (rst),
    .load_i   (cap_load),
    .over_i   (cap_over),
    .cnt_i    (cnt),
    .result_o (result_o),
    .ovr_o    (ovr_o)
  );

  // Length of the current input window, for the window check below.
  logic [RUN_W-1:0] in_run_q;
  always_ff @(posedge clk) begin
    if (rst)           in_run_q <= '0;
    else if (sel_in_o) in_run_q <= in_run_q + 1'b1;
    else               in_run_q <= '0;
  end

  // R4
  switch_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({az_o, sel_in_o, sel_ref_o}));

  // R4
  switch_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_ref_o) |-> !$past(sel_in_o));

  // R3
  in_window_max_chk: assert property (@(posedge clk) disable iff (rst)
    sel_in_o |-> in_run_q < RUN_W'(INT_LEN));

  // R3
  in_window_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_in_o) |-> in_run_q == RUN_W'(INT_LEN));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R2
  az_after_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(az_o) |-> $past(state_q == ST_IDLE));

endmodule

// File: tb/dual_slope_seq_test.sv
module dual_slope_seq_test;

  localparam int INT_LEN = 256;
  localparam int AZ_LEN  = 4;
  localparam int SYNC    = 2;
  localparam int RES_W   = $clog2(2 * INT_LEN);
  localparam int FULL    = 2 * INT_LEN - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic cont_i = 1'b0;
  logic cmp_i;
  logic az_o, sel_in_o, sel_ref_o, ovr_o, done_o;
  logic [RES_W-1:0] result_o;

  int n_total = 0;
  int n_fail  = 0;
  int cyc     = 0;

  // integrator model
  int acc = 0;
  int vin_v = 0;
  int vref_v = 1;
  assign cmp_i = (acc > 0);

  // port monitors
  int az_cnt = 0, in_cnt = 0, ref_cnt = 0;
  bit overlap_seen = 1'b0, gap_bad = 1'b0;
  logic prev_in = 1'b0;

  always #2 clk = ~clk;

  dual_slope_seq #(.INT_LEN(INT_LEN), .AZ_LEN(AZ_LEN), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .cont_i(cont_i), .cmp_i(cmp_i),
    .az_o(az_o), .sel_in_o(sel_in_o), .sel_ref_o(sel_ref_o),
    .result_o(result_o), .ovr_o(ovr_o), .done_o(done_o)
  );

  always @(negedge clk) begin
    if (az_o)           acc = 0;
    else if (sel_in_o)  acc = acc + vin_v;
    else if (sel_ref_o) acc = acc - vref_v;
    if (az_o)      az_cnt++;
    if (sel_in_o)  in_cnt++;
    if (sel_ref_o) ref_cnt++;
    if ((32'(az_o) + 32'(sel_in_o) + 32'(sel_ref_o)) > 1) overlap_seen = 1'b1;
    if (sel_ref_o && prev_in) gap_bad = 1'b1;
    prev_in = sel_in_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 180000) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected 0 (cycles)", cyc);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  function automatic int exp_count(input int vin, input int vref);
    return (INT_LEN * vin + vref - 1) / vref;
  endfunction

  task automatic wait_done();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!done_o && guard < 5000);
  endtask

  task automatic check_result(input int vin, input int vref, input int ref_base);
    int m;
    m = exp_count(vin, vref);
    if (m > FULL - 1) begin
      chk(ovr_o == 1'b1, "R6 ovr flag", int'(ovr_o), 1);
      chk(int'(result_o) == FULL, "R6 full scale", int'(result_o), FULL);
      chk(ref_cnt - ref_base == 2 * INT_LEN, "R6 ref phase length",
          ref_cnt - ref_base, 2 * INT_LEN);
    end else begin
      chk(ovr_o == 1'b0, "R6 no ovr in range", int'(ovr_o), 0);
      chk(int'(result_o) == m, "R5 result", int'(result_o), m);
    end
  endtask

  task automatic run(input int vin, input int vref, input bit poke, output int res);
    int az_b, in_b, ref_b;
    int held;
    vin_v = vin;
    vref_v = vref;
    @(negedge clk);
    az_b = az_cnt; in_b = in_cnt; ref_b = ref_cnt;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      start_i = 1'b1;              // R8: start while busy
      @(negedge clk);
      start_i = 1'b0;
    end
    wait_done();
    chk(done_o == 1'b1, "R7 done seen", int'(done_o), 1);
    chk(az_cnt - az_b == AZ_LEN, "R2 zero phase length", az_cnt - az_b, AZ_LEN);
    chk(in_cnt - in_b == INT_LEN, "R3 input window", in_cnt - in_b, INT_LEN);
    check_result(vin, vref, ref_b);
    res = int'(result_o);
    held = res;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (k == 0) chk(done_o == 1'b0, "R7 done one cycle", int'(done_o), 0);
      chk(az_o == 1'b0, "R8 no extra conversion", int'(az_o), 0);
      chk(int'(result_o) == held, "R7 result held", int'(result_o), held);
    end
  endtask

  initial begin
    int r1, r2, k;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk({az_o, sel_in_o, sel_ref_o, done_o, ovr_o} == 5'b0, "R1 outputs in reset",
        int'({az_o, sel_in_o, sel_ref_o, done_o, ovr_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(result_o == '0 && !done_o && !az_o, "R1 idle after reset", int'(result_o), 0);

    // directed corners
    run(0, 256, 1'b0, r1);          // R5: comparator already low -> 0
    chk(r1 == 0, "R5 zero input", r1, 0);
    run(1, 256, 1'b0, r1);          // R5: smallest nonzero
    chk(r1 == 1, "R5 one step", r1, 1);
    run(510, 256, 1'b1, r1);        // R6: largest in-range code, R8 poke
    chk(r1 == 510, "R6 top in range", r1, 510);
    run(511, 256, 1'b0, r1);        // R6: first overrange
    chk(r1 == FULL, "R6 first overrange", r1, FULL);
    run(100, 200, 1'b0, r1);        // R10: scaled pair
    run(400, 800, 1'b0, r2);
    chk(r1 == r2 && r1 == 128, "R10 scale invariance", r2, r1);

    // constrained random
    for (int i = 0; i < 12; i++) begin
      int vr, vi;
      vr = int'($urandom_range(300, 40));
      vi = int'($urandom_range(2 * vr + 8, 0));
      run(vi, vr, i[0], r1);
      run(3 * vi, 3 * vr, 1'b0, r2);
      chk(r1 == r2, "R10 random scale pair", r2, r1);
    end

    // continuous mode, R9
    vin_v = 100;
    vref_v = 200;
    @(negedge clk);
    cont_i = 1'b1;
    wait_done();
    chk(int'(result_o) == 128, "R9 continuous first result", int'(result_o), 128);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!az_o && k < 10);
    chk(k == 2, "R9 restart delay", k, 2);
    wait_done();
    cont_i = 1'b0;
    chk(int'(result_o) == 128, "R9 continuous second result", int'(result_o), 128);
    repeat (6) @(negedge clk);
    chk(az_o == 1'b0 && sel_in_o == 1'b0, "R9 idle without start", int'(az_o), 0);

    chk(!overlap_seen, "R4 switches exclusive", int'(overlap_seen), 0);
    chk(!gap_bad, "R4 idle gap before reference", int'(gap_bad), 0);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule